// File: doc/BRIEF.md
# Gain Calibration Divider Engine

This block carries out a gain calibration for one of two signal paths: a voltage path and a current path. A command names the path and starts the run. The engine first forces that path's gain register to unity. It then waits a programmable settle interval so that the RMS measurement can follow the new gain. At the end of the interval it captures the path's RMS input. A restoring divider then produces one quotient bit per clock. It divides a target by the captured RMS and writes the quotient back as the new gain.

The voltage path always aims for a fixed target of 0.6. The current path aims for a software-programmed scale value, which also starts at 0.6. RMS, scale and targets are unsigned Q0.24 fractions. Gains are unsigned Q2.22, so no gain can reach 4.0. A zero RMS or a quotient of 4.0 or more is rejected and reported through sticky status bits that software clears by writing ones.

Top module: `gcal_top`

## Requirements
- R1: After reset both gain registers read 0x400000 (1.0), the scale register (address 2) reads 0x999999 (0.6), status is 0, busy and done are low.
- R2: A start pulse while idle raises busy on the next cycle and sets the selected gain register to 0x400000 in that same edge (path 0 = voltage at address 0, path 1 = current at address 1).
- R3: A voltage run writes floor(0x999999 * 2^22 / vRms) into the voltage gain register.
- R4: A current run writes floor(scale * 2^22 / iRms) into the current gain register, using the scale value held when the RMS is captured.
- R5: The RMS input is captured once, at the end of the settle interval. Changes to it during the division do not alter the result.
- R6: An RMS of zero sets status bit 0 (invalid), sets no overflow bit, and leaves the gain at 0x400000.
- R7: When target >= 4 * RMS, the run sets status bit 0 plus the path's overflow bit (bit 1 voltage, bit 2 current), and the gain stays 0x400000. A target just below that bound is accepted.
- R8: Start pulses while busy are ignored: the other path's gain is unchanged and only one done pulse appears.
- R9: Status bits are sticky and clear only where a one is written to statusClr. A bit being set and cleared in the same cycle ends up set.
- R10: Software writes through the register port take effect while idle. When an engine gain write and a software write to the same gain register fall in the same cycle, the engine value is kept.
- R11: done is a single-cycle pulse that coincides with the result write edge, and busy is low in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdStart | input | 1 | Start a calibration run |
| cmdPath | input | 1 | Path to calibrate: 0 voltage, 1 current |
| vRms | input | 24 | Voltage RMS result, Q0.24 |
| iRms | input | 24 | Current RMS result, Q0.24 |
| regWe | input | 1 | Register write enable |
| regWAddr | input | 2 | Write address: 0 voltage gain, 1 current gain, 2 scale |
| regWData | input | 24 | Write data |
| regRAddr | input | 2 | Read address (3 reads zero) |
| regRData | output | 24 | Read data, combinational |
| statusClr | input | 3 | Write-one-to-clear for status bits |
| status | output | 3 | Bit 0 invalid, bit 1 voltage overflow, bit 2 current overflow |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run strobe |

## Verification
Two updates can land on the same edge in this block. The first is a status bit being set by the engine while software clears it. The second is an engine gain write while software writes the same gain register. The bench waits until done is seen high and drives statusClr (all ones) or a register write in that very cycle. It then judges the outcome at the register port in the following cycle: the status bit must still be set, and the gain must equal the computed quotient rather than the software value.

// File: rtl/gcal_pkg.sv
package gcal_pkg;
  typedef struct packed {
    logic preset;  // force selected gain to unity
    logic load;    // capture RMS and target, seed divider
    logic step;    // one restoring-division iteration
    logic finish;  // commit quotient or flag error
  } gcal_stb_t;

  localparam logic [1:0] ADDR_VGAIN = 2'd0;
  localparam logic [1:0] ADDR_IGAIN = 2'd1;
  localparam logic [1:0] ADDR_SCALE = 2'd2;

  localparam int ST_INVALID = 0;
  localparam int ST_VOVF    = 1;
  localparam int ST_IOVF    = 2;
endpackage

// File: rtl/gcal_ctrl.sv
module gcal_ctrl
  import gcal_pkg::*;
#(
  parameter int W             = 24,
  parameter int SETTLE_CYCLES = 32
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      cmdStart,
  input  logic      cmdPath,
  input  logic      loadErr,
  output gcal_stb_t stb,
  output logic      curPath,
  output logic      busy,
  output logic      done
);
  localparam int CW = $clog2(SETTLE_CYCLES + 1);
  localparam int BW = $clog2(W);

  typedef enum logic [1:0] {S_IDLE, S_SETTLE, S_DIV, S_FIN} state_t;

  state_t        state, nxt;
  logic [CW-1:0] settleCnt;
  logic [BW-1:0] bitCnt;
  logic          pathQ;

  always_comb begin
    stb = '0;
    nxt = state;
    case (state)
      S_IDLE: if (cmdStart) begin
        stb.preset = 1'b1;
        nxt = S_SETTLE;
      end
      S_SETTLE: if (settleCnt == CW'(SETTLE_CYCLES - 1)) begin
        stb.load = 1'b1;
        nxt = loadErr ? S_FIN : S_DIV;
      end
      S_DIV: begin
        stb.step = 1'b1;
        if (bitCnt == BW'(W - 1)) nxt = S_FIN;
      end
      S_FIN: begin
        stb.finish = 1'b1;
        nxt = S_IDLE;
      end
      default: nxt = S_IDLE;
    endcase
  end

  assign curPath = (state == S_IDLE) ? cmdPath : pathQ;
  assign busy    = (state != S_IDLE);
  assign done    = (state == S_FIN);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      settleCnt <= '0;
      bitCnt    <= '0;
      pathQ     <= 1'b0;
    end else begin
      state <= nxt;
      if (stb.preset) begin
        pathQ     <= cmdPath;
        settleCnt <= '0;
      end else if (state == S_SETTLE) begin
        settleCnt <= settleCnt + 1'b1;
      end
      if (stb.load) bitCnt <= '0;
      else if (stb.step) bitCnt <= bitCnt + 1'b1;
    end
  end
endmodule

// File: rtl/gcal_dp.sv
module gcal_dp
  import gcal_pkg::*;
#(
  parameter int W    = 24,
  parameter int FRAC = 22
) (
  input  logic         clk,
  input  logic         rstN,
  input  gcal_stb_t    stb,
  input  logic         curPath,
  input  logic [W-1:0] vRms,
  input  logic [W-1:0] iRms,
  input  logic         regWe,
  input  logic [1:0]   regWAddr,
  input  logic [W-1:0] regWData,
  input  logic [1:0]   regRAddr,
  output logic [W-1:0] regRData,
  input  logic [2:0]   statusClr,
  output logic [2:0]   status,
  output logic         loadErr
);
  localparam int INT = W - FRAC;
  localparam logic [W-1:0] UNITY = W'(64'd1 << FRAC);
  localparam logic [W-1:0] TGT_V = W'((64'd3 << W) / 64'd5);

  logic [W-1:0] vGain, iGain, scale;
  logic [W-1:0] divisor, rem, quot, feed;
  logic         errZero, errOvf;

  // selection and range pre-check at capture time
  logic [W-1:0]     rmsSel, tgtSel;
  logic             isZero, isBig;
  logic [W+INT-1:0] tgtWide, rmsWide;
  always_comb begin
    rmsSel  = curPath ? iRms : vRms;
    tgtSel  = curPath ? scale : TGT_V;
    tgtWide = {{INT{1'b0}}, tgtSel};
    rmsWide = {rmsSel, {INT{1'b0}}};
    isZero  = (rmsSel == '0);
    isBig   = !isZero && (tgtWide >= rmsWide);
    loadErr = isZero || isBig;
  end

  // one restoring iteration
  logic [W:0] remShift;
  logic       fits;
  always_comb begin
    remShift = {rem, feed[W-1]};
    fits     = (remShift >= {1'b0, divisor});
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divisor <= '0;
      rem     <= '0;
      quot    <= '0;
      feed    <= '0;
      errZero <= 1'b0;
      errOvf  <= 1'b0;
    end else if (stb.load) begin
      divisor <= rmsSel;
      rem     <= tgtSel >> INT;
      feed    <= {tgtSel[INT-1:0], {FRAC{1'b0}}};
      quot    <= '0;
      errZero <= isZero;
      errOvf  <= isBig;
    end else if (stb.step) begin
      rem  <= fits ? W'(remShift - {1'b0, divisor}) : remShift[W-1:0];
      quot <= {quot[W-2:0], fits};
      feed <= feed << 1;
    end
  end

  logic commitV, commitI, presetV, presetI;
  always_comb begin
    commitV = stb.finish && !(errZero || errOvf) && !curPath;
    commitI = stb.finish && !(errZero || errOvf) &&  curPath;
    presetV = stb.preset && !curPath;
    presetI = stb.preset &&  curPath;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vGain <= UNITY;
      iGain <= UNITY;
      scale <= TGT_V;
    end else begin
      if (presetV)      vGain <= UNITY;
      else if (commitV) vGain <= quot;
      else if (regWe && regWAddr == ADDR_VGAIN) vGain <= regWData;

      if (presetI)      iGain <= UNITY;
      else if (commitI) iGain <= quot;
      else if (regWe && regWAddr == ADDR_IGAIN) iGain <= regWData;

      if (regWe && regWAddr == ADDR_SCALE) scale <= regWData;
    end
  end

  logic [2:0] setBits;
  always_comb begin
    setBits = '0;
    if (stb.finish) begin
      setBits[ST_INVALID] = errZero || errOvf;
      setBits[ST_VOVF]    = errOvf && !curPath;
      setBits[ST_IOVF]    = errOvf &&  curPath;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) status <= '0;
    else       status <= (status & ~statusClr) | setBits;
  end

  always_comb begin
    case (regRAddr)
      ADDR_VGAIN: regRData = vGain;
      ADDR_IGAIN: regRData = iGain;
      ADDR_SCALE: regRData = scale;
      default:    regRData = '0;
    endcase
  end
endmodule

// File: rtl/gcal_top.sv
module gcal_top
  import gcal_pkg::*;
#(
  parameter int W             = 24,
  parameter int FRAC          = 22,
  parameter int SETTLE_CYCLES = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         cmdStart,
  input  logic         cmdPath,
  input  logic [W-1:0] vRms,
  input  logic [W-1:0] iRms,
  input  logic         regWe,
  input  logic [1:0]   regWAddr,
  input  logic [W-1:0] regWData,
  input  logic [1:0]   regRAddr,
  output logic [W-1:0] regRData,
  input  logic [2:0]   statusClr,
  output logic [2:0]   status,
  output logic         busy,
  output logic         done
);
  gcal_stb_t stb;
  logic      curPath, loadErr;

  gcal_ctrl #(.W(W), .SETTLE_CYCLES(SETTLE_CYCLES)) uCtrl (
    .clk(clk), .rstN(rstN), .cmdStart(cmdStart), .cmdPath(cmdPath),
    .loadErr(loadErr), .stb(stb), .curPath(curPath), .busy(busy), .done(done)
  );

  gcal_dp #(.W(W), .FRAC(FRAC)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .curPath(curPath),
    .vRms(vRms), .iRms(iRms), .regWe(regWe), .regWAddr(regWAddr),
    .regWData(regWData), .regRAddr(regRAddr), .regRData(regRData),
    .statusClr(statusClr), .status(status), .loadErr(loadErr)
  );
endmodule

// File: rtl/gcal_chk.sv
module gcal_chk (
  input logic       clk,
  input logic       rstN,
  input logic       cmdStart,
  input logic [2:0] statusClr,
  input logic [2:0] status,
  input logic       busy,
  input logic       done
);
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);                                             // R11
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);                                             // R11
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (cmdStart && !busy) |=> busy);                               // R2
  AST_NO_SPONTANEOUS_RUN: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !cmdStart) |=> !busy);                             // R8
  AST_RUN_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> busy);                                   // R8
  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (|(status & ~statusClr)) |=>
      ((status & $past(status & ~statusClr)) == $past(status & ~statusClr))); // R9
  AST_STATUS_SET_AT_DONE: assert property (@(posedge clk) disable iff (!rstN)
    !done |=> ((status & ~$past(status)) == 3'b000));            // R6
  AST_OVF_WITH_INVALID: assert property (@(posedge clk) disable iff (!rstN)
    (done && (status[0] == 1'b0)) |=> (status[2:1] == 2'b00 || status[0])); // R7
endmodule

bind gcal_top gcal_chk uChk (
  .clk(clk), .rstN(rstN), .cmdStart(cmdStart), .statusClr(statusClr),
  .status(status), .busy(busy), .done(done)
);

// File: tb/sim_gcal_top.sv
module sim_gcal_top;
  localparam int SETTLE = 32;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdStart = 1'b0, cmdPath = 1'b0;
  logic [23:0] vRms = '0, iRms = '0;
  logic        regWe = 1'b0;
  logic [1:0]  regWAddr = '0, regRAddr = '0;
  logic [23:0] regWData = '0, regRData;
  logic [2:0]  statusClr = '0, status;
  logic        busy, done;

  int checks = 0, failures = 0, doneSeen = 0;

  typedef struct {
    logic        path;
    logic [23:0] gain;
    logic [2:0]  stat;
    string       tag;
  } item_t;
  item_t expQ[$];

  always #2 clk = ~clk;

  gcal_top #(.SETTLE_CYCLES(SETTLE)) u0 (
    .clk(clk), .rstN(rstN), .cmdStart(cmdStart), .cmdPath(cmdPath),
    .vRms(vRms), .iRms(iRms), .regWe(regWe), .regWAddr(regWAddr),
    .regWData(regWData), .regRAddr(regRAddr), .regRData(regRData),
    .statusClr(statusClr), .status(status), .busy(busy), .done(done)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] quo(input logic [23:0] t, input logic [23:0] r);
    logic [47:0] n;
    n = {24'd0, t} << 22;
    return 24'(n / {24'd0, r});
  endfunction

  task automatic readReg(input logic [1:0] a, output logic [23:0] d);
    regRAddr = a;
    #1;
    d = regRData;
  endtask

  // monitor: pops one expected item per done pulse
  initial begin
    item_t it;
    logic [23:0] g;
    forever begin
      @(negedge clk);
      if (done) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R8 unexpected done", 32'd1, 32'd0);
        end else begin
          it = expQ.pop_front();
          @(negedge clk);
          check(!done && !busy, {"R11 pulse/busy ", it.tag}, {30'd0, done, busy}, 32'd0);
          readReg(it.path ? 2'd1 : 2'd0, g);
          check(g == it.gain, {"gain ", it.tag}, {8'd0, g}, {8'd0, it.gain});
          check(status == it.stat, {"status ", it.tag}, {29'd0, status}, {29'd0, it.stat});
        end
        doneSeen++;
      end
    end
  end

  // driver: mode 0 plain, 1 clear collision, 2 write collision, 3 RMS change, 4 extra start
  task automatic runCal(input logic path, input logic [23:0] rms, input logic [23:0] expG,
                        input logic [2:0] expS, input int mode, input string tag);
    item_t it;
    logic [23:0] g;
    int target;
    it.path = path; it.gain = expG; it.stat = expS; it.tag = tag;
    expQ.push_back(it);
    target = doneSeen + 1;
    if (path) iRms = rms; else vRms = rms;
    @(negedge clk);
    cmdStart = 1'b1; cmdPath = path;
    @(negedge clk);
    cmdStart = 1'b0;
    readReg(path ? 2'd1 : 2'd0, g);
    check(busy && g == 24'h400000, {"R2 preset/busy ", tag}, {7'd0, busy, g}, {8'd1, 24'h400000});
    if (mode == 4) begin
      cmdStart = 1'b1; cmdPath = ~path;
      @(negedge clk);
      cmdStart = 1'b0;
    end
    if (mode == 3) begin
      repeat (SETTLE + 6) @(negedge clk);
      if (path) iRms = 24'h123457; else vRms = 24'h123457;
    end
    if (mode == 1 || mode == 2) begin
      do @(negedge clk); while (!done);
      if (mode == 1) statusClr = 3'b111;
      else begin regWe = 1'b1; regWAddr = path ? 2'd1 : 2'd0; regWData = 24'h123456; end
      @(negedge clk);
      statusClr = '0; regWe = 1'b0;
    end
    wait (doneSeen >= target);
    repeat (3) @(negedge clk);
    statusClr = 3'b111;
    @(negedge clk);
    statusClr = '0;
  endtask

  task automatic swWrite(input logic [1:0] a, input logic [23:0] d);
    @(negedge clk);
    regWe = 1'b1; regWAddr = a; regWData = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  initial begin
    logic [23:0] g, keepI;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    readReg(2'd0, g); check(g == 24'h400000, "R1 vGain reset", {8'd0, g}, 32'h400000);
    readReg(2'd1, g); check(g == 24'h400000, "R1 iGain reset", {8'd0, g}, 32'h400000);
    readReg(2'd2, g); check(g == 24'h999999, "R1 scale reset", {8'd0, g}, 32'h999999);
    check(status == 3'b000 && !busy && !done, "R1 status/busy", {29'd0, status}, 32'd0);

    // R3 voltage runs
    runCal(1'b0, 24'h400000, quo(24'h999999, 24'h400000), 3'b000, 0, "R3 vrms 0.25");
    runCal(1'b0, 24'hC00000, quo(24'h999999, 24'hC00000), 3'b000, 0, "R3 vrms 0.75");
    // R4 current runs with default and programmed scale
    runCal(1'b1, 24'h999999, 24'h400000, 3'b000, 0, "R4 default scale");
    swWrite(2'd2, 24'h300000);
    readReg(2'd2, g); check(g == 24'h300000, "R10 scale write idle", {8'd0, g}, 32'h300000);
    runCal(1'b1, 24'h800000, quo(24'h300000, 24'h800000), 3'b000, 0, "R4 scale 0x300000");
    // R5 RMS changed mid-division
    runCal(1'b0, 24'h555555, quo(24'h999999, 24'h555555), 3'b000, 3, "R5 capture once");
    // R6 zero RMS
    runCal(1'b0, 24'h000000, 24'h400000, 3'b001, 0, "R6 zero vrms");
    runCal(1'b1, 24'h000000, 24'h400000, 3'b001, 0, "R6 zero irms");
    // R7 ceiling
    runCal(1'b0, 24'h200000, 24'h400000, 3'b011, 0, "R7 voltage over 4");
    swWrite(2'd2, 24'h800000);
    runCal(1'b1, 24'h200000, 24'h400000, 3'b101, 0, "R7 current exactly 4");
    runCal(1'b1, 24'h200001, quo(24'h800000, 24'h200001), 3'b000, 0, "R7 just below 4");
    // R8 start while busy ignored
    readReg(2'd1, keepI);
    runCal(1'b0, 24'h666666, quo(24'h999999, 24'h666666), 3'b000, 4, "R8 busy start");
    readReg(2'd1, g); check(g == keepI, "R8 other path untouched", {8'd0, g}, {8'd0, keepI});
    // R9 set and clear collide
    runCal(1'b0, 24'h000000, 24'h400000, 3'b001, 1, "R9 set beats clear");
    // R10 engine write beats software write
    runCal(1'b0, 24'h700000, quo(24'h999999, 24'h700000), 3'b000, 2, "R10 engine wins");
    swWrite(2'd0, 24'h0ABCDE);
    readReg(2'd0, g); check(g == 24'h0ABCDE, "R10 gain write idle", {8'd0, g}, 32'h0ABCDE);
    check(expQ.size() == 0, "R11 all results seen", expQ.size(), 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule